// File: doc/BRIEF.md
# Serial Flash Clock and Select Timing Generator

This block produces the serial clock and the active-low device-select lines for a serial flash port, all timed in reference-clock cycles. A shifter elsewhere raises a frame request, reacts to the shift and sample strobes, and reports the end of its data with a one-cycle done pulse. The block then finishes the current clock period and deasserts the select. It enforces a programmable select-to-first-edge delay, a last-edge-to-deselect delay, a minimum deselect time, and an extra wait whenever the next frame targets a different device. Each of these delays is an 8-bit count of reference clocks.

The clock rate comes from a 4-bit divider. Polarity and phase bits pick one of the four SPI modes. The select field drives the pins either as an active-low one-hot code or unchanged, as a device number for an external decoder. All settings are taken into a shadow copy only while the enable input is low and no frame is in progress. Frames start only while enable is high.

Top module: `spi_frame_timer`

## Requirements
- R1: After reset, cs_n is all ones, sclk is low (polarity input low), both strobes are low and idle is high.
- R2: During a frame, every SCLK half period lasts exactly div+1 reference clocks, so one SCLK period is 2*(div+1) reference clocks.
- R3: SCLK rests at the polarity level (cpol=1 means high) whenever no device is selected, and a frame with N data bits gives exactly 2*N SCLK edges.
- R4: With cpha=0, sample_stb pulses on each leading (away-from-idle) edge and shift_stb on each trailing edge. With cpha=1 the two roles swap. Each strobe is high only in the cycle in which sclk has just changed.
- R5: With decoding off, selecting device n (low two bits of dev_sel) drives cs_n to 4'hF with bit n cleared, and at most one line is low at any time.
- R6: With decoding on, cs_n carries dev_sel unchanged while a frame is active, and 4'hF otherwise.
- R7: The first SCLK edge comes t_setup+1 reference clocks after cs_n asserts.
- R8: A done pulse ends the frame at the next trailing edge, counting one that falls in the same cycle. cs_n deasserts t_hold + 2*(div+1) + 3 reference clocks after that last edge.
- R9: A frame to the same device asserts cs_n no earlier than t_gap + 2*(div+1) + 1 reference clocks after the previous deassertion, and exactly then if the request is already waiting.
- R10: A frame to a different device waits the larger of the R9 time and t_switch+1 reference clocks after deassertion. t_switch has no effect on a frame to the same device.
- R11: Configuration inputs are taken only while enable is low and no frame is active. A request while enable is low starts no frame.
- R12: idle is high only when no frame is active and both the deselect and the device-switch counters have run out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global enable; low opens the configuration shadow |
| xfer_req | input | 1 | Frame request from the shifter |
| xfer_done | input | 1 | Shifter has presented its last bit |
| div_sel | input | DIV_W | Clock divider value |
| cpol | input | 1 | Clock polarity |
| cpha | input | 1 | Clock phase |
| dev_sel | input | NCS | Device select field |
| dev_decode | input | 1 | 1: pass dev_sel as an encoded number |
| t_setup | input | DLY_W | Select-to-first-edge delay |
| t_hold | input | DLY_W | Last-edge-to-deselect delay |
| t_gap | input | DLY_W | Minimum deselect time |
| t_switch | input | DLY_W | Extra delay when the device changes |
| sclk | output | 1 | Serial clock |
| cs_n | output | NCS | Active-low select bus |
| shift_stb | output | 1 | Shifter must drive the next bit |
| sample_stb | output | 1 | Shifter must capture the input bit |
| idle | output | 1 | No frame and no pending deselect wait |

## Verification
With a divider of zero, the done pulse the shifter gives right after the final leading edge is sampled in the same cycle as the trailing edge that ends the frame. That trailing edge must close the frame at once, not one period later. The bench provokes this with div=0 and judges it by the total edge count and the hold interval. A second collision comes from a request held high through the deselect interval: it meets the deselect counter's expiry in one cycle, and the measured gap must equal the programmed minimum exactly. The device-switch case also lands a configuration reload in the cycle right after deassertion, while both counters are running.

// File: rtl/spi_tim_pkg.sv
package spi_tim_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_RUN   = 2'd2,
        PH_HOLD  = 2'd3
    } phase_e;
endpackage

// File: rtl/spi_cfg_shadow.sv
module spi_cfg_shadow #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] cfg_in,
    output logic [W-1:0] cfg_out
);
    logic [W-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load) cfg_d = cfg_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_out = cfg_q;
endmodule

// File: rtl/spi_gap_cnt.sv
module spi_gap_cnt #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)             cnt_d = load_val;
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/spi_cs_map.sv
module spi_cs_map #(
    parameter int NCS = 4
) (
    input  logic           active,
    input  logic           decode,
    input  logic [NCS-1:0] dev,
    output logic [NCS-1:0] cs_n
);
    localparam int IW = (NCS > 1) ? $clog2(NCS) : 1;

    for (genvar i = 0; i < NCS; i++) begin : g_pin
        assign cs_n[i] = !active ? 1'b1
                       : (decode ? dev[i] : (dev[IW-1:0] != IW'(i)));
    end
endmodule

// File: rtl/spi_frame_timer.sv
module spi_frame_timer
    import spi_tim_pkg::*;
#(
    parameter int DIV_W = 4,
    parameter int DLY_W = 8,
    parameter int NCS   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             xfer_req,
    input  logic             xfer_done,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             cpol,
    input  logic             cpha,
    input  logic [NCS-1:0]   dev_sel,
    input  logic             dev_decode,
    input  logic [DLY_W-1:0] t_setup,
    input  logic [DLY_W-1:0] t_hold,
    input  logic [DLY_W-1:0] t_gap,
    input  logic [DLY_W-1:0] t_switch,
    output logic             sclk,
    output logic [NCS-1:0]   cs_n,
    output logic             shift_stb,
    output logic             sample_stb,
    output logic             idle
);
    // counter wide enough for hold + full period + margin
    localparam int CW = ((DLY_W > DIV_W + 1) ? DLY_W : DIV_W + 1) + 2;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             cpol;
        logic             cpha;
        logic [NCS-1:0]   dev;
        logic             decode;
        logic [DLY_W-1:0] setup;
        logic [DLY_W-1:0] hold;
        logic [DLY_W-1:0] gap;
        logic [DLY_W-1:0] sw;
    } cfg_t;

    typedef struct packed {
        phase_e         ph;
        logic [CW-1:0]  cnt;
        logic           tog;
        logic           stop;
        logic           shift;
        logic           sample;
        logic [NCS-1:0] last_dev;
    } st_t;

    localparam int CFG_W = $bits(cfg_t);

    cfg_t cfg_in, cfg_q;
    st_t  s_d, s_q;
    logic gap_zero, sw_zero, gap_load;
    logic act_cpol, act_decode;
    logic [CW-1:0] div_ext, per_len, hold_ld, gap_ld, sw_ld;

    assign cfg_in = '{div: div_sel, cpol: cpol, cpha: cpha, dev: dev_sel,
                      decode: dev_decode, setup: t_setup, hold: t_hold,
                      gap: t_gap, sw: t_switch};

    spi_cfg_shadow #(.W(CFG_W)) u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (!enable && (s_q.ph == PH_IDLE)),
        .cfg_in (cfg_in),
        .cfg_out(cfg_q)
    );

    assign div_ext = CW'(cfg_q.div);
    assign per_len = (div_ext + CW'(1)) << 1;
    assign hold_ld = CW'(cfg_q.hold) + per_len + CW'(2);
    assign gap_ld  = CW'(cfg_q.gap) + per_len;
    assign sw_ld   = CW'(cfg_q.sw);

    spi_gap_cnt #(.W(CW)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gap_load),
        .load_val(gap_ld),
        .zero    (gap_zero)
    );

    spi_gap_cnt #(.W(CW)) u_switch (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gap_load),
        .load_val(sw_ld),
        .zero    (sw_zero)
    );

    always_comb begin
        logic stop_now;
        s_d       = s_q;
        s_d.shift  = 1'b0;
        s_d.sample = 1'b0;
        gap_load  = 1'b0;
        stop_now  = s_q.stop | xfer_done;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (enable && xfer_req && gap_zero &&
                    ((cfg_q.dev == s_q.last_dev) || sw_zero)) begin
                    s_d.ph       = PH_SETUP;
                    s_d.cnt      = CW'(cfg_q.setup);
                    s_d.stop     = 1'b0;
                    s_d.last_dev = cfg_q.dev;
                end
            end
            PH_SETUP: begin
                s_d.stop = stop_now;
                if (s_q.cnt == '0) begin
                    s_d.ph     = PH_RUN;
                    s_d.tog    = 1'b1;
                    s_d.cnt    = div_ext;
                    s_d.shift  = cfg_q.cpha;
                    s_d.sample = !cfg_q.cpha;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_RUN: begin
                s_d.stop = stop_now;
                if (s_q.cnt == '0) begin
                    s_d.tog = !s_q.tog;
                    if (!s_q.tog) begin
                        // leading edge
                        s_d.shift  = cfg_q.cpha;
                        s_d.sample = !cfg_q.cpha;
                        s_d.cnt    = div_ext;
                    end else begin
                        // trailing edge
                        s_d.shift  = !cfg_q.cpha;
                        s_d.sample = cfg_q.cpha;
                        if (stop_now) begin
                            s_d.ph  = PH_HOLD;
                            s_d.cnt = hold_ld;
                        end else begin
                            s_d.cnt = div_ext;
                        end
                    end
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_HOLD: begin
                if (s_q.cnt == '0) begin
                    s_d.ph   = PH_IDLE;
                    gap_load = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ph       <= PH_IDLE;
            s_q.cnt      <= '0;
            s_q.tog      <= 1'b0;
            s_q.stop     <= 1'b0;
            s_q.shift    <= 1'b0;
            s_q.sample   <= 1'b0;
            s_q.last_dev <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign act_cpol   = cfg_q.cpol;
    assign act_decode = cfg_q.decode;

    spi_cs_map #(.NCS(NCS)) u_cs (
        .active(s_q.ph != PH_IDLE),
        .decode(act_decode),
        .dev   (cfg_q.dev),
        .cs_n  (cs_n)
    );

    assign sclk       = act_cpol ^ s_q.tog;
    assign shift_stb  = s_q.shift;
    assign sample_stb = s_q.sample;
    assign idle       = (s_q.ph == PH_IDLE) && gap_zero && sw_zero;
endmodule

// File: rtl/spi_frame_timer_chk.sv
module spi_frame_timer_chk #(
    parameter int NCS = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           enable,
    input logic           sclk,
    input logic [NCS-1:0] cs_n,
    input logic           shift_stb,
    input logic           sample_stb,
    input logic           idle,
    input logic           cur_cpol,
    input logic           cur_decode
);
    // R3
    sclk_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_decode && cs_n == '1) |-> (sclk == cur_cpol));

    // R4
    strobe_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_stb || sample_stb) |-> (sclk != $past(sclk)));

    // R5
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_decode |-> ($countones(~cs_n) <= 1));

    // R12
    idle_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (cs_n == '1));

    // R11
    start_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_decode && cs_n != '1 && $past(cs_n) == '1) |-> $past(enable));

    // R6
    select_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != '1 && $past(cs_n) != '1) |-> $stable(cs_n));
endmodule

bind spi_frame_timer spi_frame_timer_chk #(.NCS(NCS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .shift_stb (shift_stb),
    .sample_stb(sample_stb),
    .idle      (idle),
    .cur_cpol  (act_cpol),
    .cur_decode(act_decode)
);

// File: tb/spi_frame_timer_bench.sv
`timescale 1ns/1ps
module spi_frame_timer_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, xfer_req = 1'b0, xfer_done = 1'b0;
    logic [3:0] div_sel = '0;
    logic cpol = 1'b0, cpha = 1'b0, dev_decode = 1'b0;
    logic [3:0] dev_sel = '0;
    logic [7:0] t_setup = '0, t_hold = '0, t_gap = '0, t_switch = '0;
    logic sclk, shift_stb, sample_stb, idle;
    logic [3:0] cs_n;

    always #2.5 clk = ~clk;

    spi_frame_timer u_spi_frame_timer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .xfer_req(xfer_req),
        .xfer_done(xfer_done), .div_sel(div_sel), .cpol(cpol), .cpha(cpha),
        .dev_sel(dev_sel), .dev_decode(dev_decode), .t_setup(t_setup),
        .t_hold(t_hold), .t_gap(t_gap), .t_switch(t_switch), .sclk(sclk),
        .cs_n(cs_n), .shift_stb(shift_stb), .sample_stb(sample_stb), .idle(idle)
    );

    int tests = 0, fails = 0, cyc = 0;
    int exp_cpol = 0, exp_cpha = 0;
    int t_asr = 0, t_deas = 0, t_first = 0, t_last = 0, gap_meas = 0;
    int edges = 0, min_h = 0, max_h = 0, strobe_err = 0, rest_err = 0, n_asr = 0;
    logic [3:0] cs_seen = '0;
    logic prev_sclk = 1'b0;
    logic [3:0] prev_cs = 4'hF;
    bit done_flag = 0;

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done_flag) begin
            done_flag = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual=%0d expected<=100000", cyc);
            summary();
        end
    end

    // passive monitor, samples between clock edges
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_cs == 4'hF && cs_n != 4'hF) begin
                t_asr = cyc; gap_meas = cyc - t_deas; edges = 0;
                min_h = 9999; max_h = 0; cs_seen = cs_n; n_asr++;
            end
            if (prev_cs != 4'hF && cs_n == 4'hF) t_deas = cyc;
            if (sclk != prev_sclk) begin
                if (cs_n != 4'hF) begin
                    bit lead;
                    if (edges == 0) t_first = cyc;
                    else begin
                        if (cyc - t_last < min_h) min_h = cyc - t_last;
                        if (cyc - t_last > max_h) max_h = cyc - t_last;
                    end
                    t_last = cyc;
                    edges++;
                    lead = (int'(prev_sclk) == exp_cpol);
                    if (sample_stb != (lead ^ exp_cpha[0]) ||
                        shift_stb != !(lead ^ exp_cpha[0])) strobe_err++;
                end
            end else if (shift_stb || sample_stb) strobe_err++;
            if (cs_n == 4'hF && int'(sclk) != exp_cpol) rest_err++;
        end
        prev_sclk = sclk;
        prev_cs   = cs_n;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic configure(input int c_div, c_cpol, c_cpha, c_dev, c_dec,
                             c_setup, c_hold, c_gap, c_sw);
        tick();
        enable = 0;
        div_sel = 4'(c_div); cpol = 1'(c_cpol); cpha = 1'(c_cpha);
        dev_sel = 4'(c_dev); dev_decode = 1'(c_dec);
        t_setup = 8'(c_setup); t_hold = 8'(c_hold);
        t_gap = 8'(c_gap); t_switch = 8'(c_sw);
        exp_cpol = c_cpol; exp_cpha = c_cpha;
        tick(); tick();
        enable = 1;
    endtask

    task automatic frame(input int bits, input bit keep);
        tick();
        xfer_req = 1;
        do tick(); while (cs_n == 4'hF);
        xfer_req = keep;
        while (edges < 2 * bits - 1) tick();
        xfer_done = 1;
        tick();
        xfer_done = 0;
        while (cs_n != 4'hF) tick();
    endtask

    task automatic t_reset();
        chk(cs_n == 4'hF, "R1 cs_n", int'(cs_n), 15);
        chk(idle == 1'b1, "R1 idle", int'(idle), 1);
        chk(!shift_stb && !sample_stb, "R1 strobes", int'({shift_stb, sample_stb}), 0);
        chk(sclk == 1'b0, "R1 sclk", int'(sclk), 0);
    endtask

    task automatic t_mode(input int c_cpol, c_cpha, c_div, c_setup, c_hold, c_dev, bits);
        int se, re;
        logic [3:0] exp_cs;
        configure(c_div, c_cpol, c_cpha, c_dev, 0, c_setup, c_hold, 0, 0);
        repeat (20) tick();
        se = strobe_err; re = rest_err;
        chk(int'(sclk) == c_cpol, "R3 rest level before", int'(sclk), c_cpol);
        frame(bits, 0);
        exp_cs = 4'hF & ~(4'b1 << (c_dev % 4));
        chk(cs_seen == exp_cs, "R5 one-hot select", int'(cs_seen), int'(exp_cs));
        chk(edges == 2 * bits, "R3 edge count", edges, 2 * bits);
        chk(min_h == c_div + 1 && max_h == c_div + 1, "R2 half period", max_h, c_div + 1);
        chk(t_first - t_asr == c_setup + 1, "R7 setup", t_first - t_asr, c_setup + 1);
        chk(t_deas - t_last == c_hold + 2 * (c_div + 1) + 3, "R8 hold",
            t_deas - t_last, c_hold + 2 * (c_div + 1) + 3);
        chk(strobe_err == se, "R4 strobes", strobe_err - se, 0);
        tick();
        chk(int'(sclk) == c_cpol && rest_err == re, "R3 rest level after", rest_err - re, 0);
    endtask

    task automatic t_decode();
        configure(1, 0, 0, 4'hA, 1, 2, 1, 0, 0);
        repeat (20) tick();
        frame(2, 0);
        chk(cs_seen == 4'hA, "R6 decoded select", int'(cs_seen), 10);
        tick();
        chk(cs_n == 4'hF, "R6 released", int'(cs_n), 15);
    endtask

    task automatic t_gap_same();
        configure(0, 0, 0, 1, 0, 0, 0, 2, 0);
        repeat (20) tick();
        frame(1, 1);
        chk(idle == 1'b0, "R12 idle low in gap", int'(idle), 0);
        frame(1, 0);
        chk(gap_meas == 5, "R9 minimum deselect", gap_meas, 5);
        repeat (20) tick();
        chk(idle == 1'b1, "R12 idle after gap", int'(idle), 1);
    endtask

    task automatic t_switch_dev();
        configure(0, 0, 0, 0, 0, 0, 0, 0, 20);
        repeat (40) tick();
        frame(1, 0);
        enable = 0; dev_sel = 4'h1;
        tick();
        enable = 1;
        frame(1, 0);
        chk(gap_meas == 21, "R10 device switch wait", gap_meas, 21);
        chk(cs_seen == 4'hD, "R10 new device", int'(cs_seen), 13);
        frame(1, 1);
        frame(1, 0);
        chk(gap_meas == 3, "R10 same device ignores switch", gap_meas, 3);
        repeat (40) tick();
    endtask

    task automatic t_enable();
        int n0;
        configure(1, 0, 0, 2, 0, 0, 0, 0, 0);
        repeat (20) tick();
        enable = 0; xfer_req = 1; n0 = n_asr;
        repeat (30) tick();
        chk(n_asr == n0 && cs_n == 4'hF, "R11 request ignored while disabled", n_asr - n0, 0);
        xfer_req = 0; enable = 1;
        tick();
        div_sel = 4'd5;
        frame(1, 0);
        chk(min_h == 2 && max_h == 2, "R11 config frozen while enabled", max_h, 2);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        #1 rst_n = 1;
        tick();
        t_reset();
        t_mode(0, 0, 0, 0, 0, 0, 1);
        t_mode(1, 0, 3, 4, 2, 1, 3);
        t_mode(0, 1, 1, 1, 5, 2, 2);
        t_mode(1, 1, 15, 0, 0, 3, 2);
        t_decode();
        t_gap_same();
        t_switch_dev();
        t_enable();
        done_flag = 1;
        summary();
    end
endmodule